// File: doc/BRIEF.md
# Register-Bus to MAC Host Configuration Bridge

This block lets a processor reach the host configuration port of either of two Ethernet MAC instances through four registers on a simple word-addressed register bus. Software places the outgoing word in the low data register. It then writes the control register with an instance select, a write-enable flag and a five-bit access code. That control write starts the access. The bridge expands the code into the sparse 10-bit host address. It drives the address, write data and strobes for one cycle to the chosen instance only, and the other instance sees all-zero inputs. A per-instance ready bit reports when the access has finished.

Three of the codes reach storage inside the bridge: an interrupt status word, an interrupt enable word and a management write-data word. These codes raise no MAC strobe. The management control code is sent to the MAC with the management-select and request strobes raised, and it carries the stored management word as its data. Reads return their result in the low data register and clear the high one. Data words pass straight through by bit index, with no reordering in either direction.

The controller is a four-state machine. The states are IDLE (no access), ISSUE (a one-cycle host strobe), WAIT (waiting for the MAC's done pulse) and LOCAL (an access served in the bridge). The transitions are START_MAC (IDLE to ISSUE on a control write whose code targets the MAC) and START_LOCAL (IDLE to LOCAL on a local or unmapped code). POST_DONE goes from ISSUE to IDLE for a configuration write. AWAIT goes from ISSUE to WAIT for a read or management access. CAPTURE goes from WAIT to IDLE on done, and LOCAL_DONE goes from LOCAL to IDLE after one cycle.

Top module: `regbus_mac_bridge`

## Requirements
- R1: After reset, ready reads 0x0000_0003: both ready bits are set and the error bit is clear. The data, control and local words all read zero.
- R2: The bus registers sit at word address 0 (data high), 1 (data low), 2 (control) and 3 (ready). The control register holds the code in bits 4:0, write-enable in bit 8 and the instance select in bit 16. The ready register holds instance ready in bits 0 and 1 and the error flag in bit 8. The control register reads back the latched fields.
- R3: A control write while IDLE starts an access. The ready bit of the selected instance reads 0 in the cycle after the write.
- R4: Codes 0 to 11 map to host addresses 0x200, 0x240, 0x280, 0x2C0, 0x300, 0x320, 0x340, 0x380, 0x384, 0x388, 0x38C and 0x390. Code 15 maps to 0x3B4.
- R5: A MAC access drives a single-cycle strobe to the selected instance only. The opcode is 01 for a write and 10 for a read. Management-select and request are 1 only for code 15. Host outputs that are not strobing are all zero.
- R6: Host write data is the low data word for codes 0 to 11 and the management write-data word for code 15. Bit n of the register appears on host bit n; for example, 0x0000_0001 stays 0x0000_0001.
- R7: A configuration write (codes 0 to 11) sets the ready bit again one cycle after the strobe.
- R8: Reads and code-15 accesses wait for the selected instance's done pulse. A read then loads host read data into data low, clears data high and sets ready.
- R9: Codes 12, 13 and 14 (interrupt status, interrupt enable, management write data) raise no strobe. A write stores data low. A read returns the word in data low with data high zero. Both complete after one cycle.
- R10: Codes 16 to 31 raise no strobe and complete after one cycle. A read returns zero in both data words.
- R11: A control write while an access is pending is ignored, so the control readback and the strobes are unchanged. It sets the sticky error bit, which clears only when ready is written with bit 8 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register bus write strobe |
| bus_addr | input | 2 | Register bus word address |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data (combinational on bus_addr) |
| host_addr | output | 2x10 | Host address per instance |
| host_wrdata | output | 2x32 | Host write data per instance |
| host_opcode | output | 2x2 | Host opcode per instance (01 write, 10 read, 00 idle) |
| host_mgmt_sel | output | 2 | Management-select strobe per instance |
| host_req | output | 2 | Request strobe per instance |
| host_rddata | input | 2x32 | Read data returned by each instance |
| host_done | input | 2 | Access-done pulse from each instance |

## Verification
The main function is driven with configuration writes over every mapped code on alternating instances. This separates correct address translation from an off-by-one or swapped table entry, and it catches a strobe that reaches the wrong instance. Reads, management-control accesses and local codes are tried in turn, so a wrong completion path shows up as ready rising early or late, or as the wrong word landing in the data pair. Single-bit data patterns at the two extreme bit positions show any reordering of bits. A control write placed in the middle of a pending read, and unmapped codes, show whether stray accesses are correctly ignored or completed empty.

// File: rtl/mac_bridge_pkg.sv
package mac_bridge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_LOCAL = 2'd3
    } bstate_t;

    typedef enum logic [1:0] {
        K_CFG   = 2'd0,
        K_MGMT  = 2'd1,
        K_LOCAL = 2'd2,
        K_NONE  = 2'd3
    } kind_t;

    localparam logic [1:0] OP_IDLE = 2'b00;
    localparam logic [1:0] OP_WR   = 2'b01;
    localparam logic [1:0] OP_RD   = 2'b10;

    localparam logic [1:0] RA_DHI  = 2'd0;
    localparam logic [1:0] RA_DLO  = 2'd1;
    localparam logic [1:0] RA_CTRL = 2'd2;
    localparam logic [1:0] RA_RDY  = 2'd3;

    localparam int F_CODE_LSB = 0;
    localparam int F_WE_BIT   = 8;
    localparam int F_SEL_LSB  = 16;
    localparam int F_ERR_BIT  = 8;

endpackage

// File: rtl/mb_code_map.sv
module mb_code_map
    import mac_bridge_pkg::*;
#(
    parameter int CODE_W  = 5,
    parameter int HADDR_W = 10
) (
    input  logic [CODE_W-1:0]  code,
    output kind_t              kind,
    output logic [HADDR_W-1:0] haddr,
    output logic [1:0]         lidx
);

    // Sparse host address for each MAC-bound code
    always_comb begin
        kind  = K_NONE;
        haddr = '0;
        lidx  = code[1:0];
        case (32'(code))
            0:  begin kind = K_CFG;  haddr = HADDR_W'(10'h200); end
            1:  begin kind = K_CFG;  haddr = HADDR_W'(10'h240); end
            2:  begin kind = K_CFG;  haddr = HADDR_W'(10'h280); end
            3:  begin kind = K_CFG;  haddr = HADDR_W'(10'h2C0); end
            4:  begin kind = K_CFG;  haddr = HADDR_W'(10'h300); end
            5:  begin kind = K_CFG;  haddr = HADDR_W'(10'h320); end
            6:  begin kind = K_CFG;  haddr = HADDR_W'(10'h340); end
            7:  begin kind = K_CFG;  haddr = HADDR_W'(10'h380); end
            8:  begin kind = K_CFG;  haddr = HADDR_W'(10'h384); end
            9:  begin kind = K_CFG;  haddr = HADDR_W'(10'h388); end
            10: begin kind = K_CFG;  haddr = HADDR_W'(10'h38C); end
            11: begin kind = K_CFG;  haddr = HADDR_W'(10'h390); end
            12, 13, 14: kind = K_LOCAL;
            15: begin kind = K_MGMT; haddr = HADDR_W'(10'h3B4); end
            default: kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/mb_host_fanout.sv
module mb_host_fanout #(
    parameter int NUM_INST = 2,
    parameter int DATA_W   = 32,
    parameter int HADDR_W  = 10,
    parameter int SEL_W    = 1
) (
    input  logic                               active,
    input  logic [SEL_W-1:0]                   sel,
    input  logic [HADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                  wdata,
    input  logic [1:0]                         opcode,
    input  logic                               msel,
    input  logic                               req,
    output logic [NUM_INST-1:0][HADDR_W-1:0]   host_addr,
    output logic [NUM_INST-1:0][DATA_W-1:0]    host_wrdata,
    output logic [NUM_INST-1:0][1:0]           host_opcode,
    output logic [NUM_INST-1:0]                host_mgmt_sel,
    output logic [NUM_INST-1:0]                host_req
);

    for (genvar i = 0; i < NUM_INST; i++) begin : g_inst
        logic hit;
        assign hit              = active && (sel == SEL_W'(i));
        assign host_addr[i]     = hit ? addr   : '0;
        assign host_wrdata[i]   = hit ? wdata  : '0;
        assign host_opcode[i]   = hit ? opcode : 2'b00;
        assign host_mgmt_sel[i] = hit && msel;
        assign host_req[i]      = hit && req;
    end

endmodule

// File: rtl/mb_ctrl_fsm.sv
module mb_ctrl_fsm
    import mac_bridge_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  kind_t   start_kind,
    input  kind_t   cur_kind,
    input  logic    cur_we,
    input  logic    done,
    output bstate_t state,
    output logic    issue,
    output logic    busy,
    output logic    finish
);

    bstate_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (start_kind == K_CFG || start_kind == K_MGMT) nxt = ST_ISSUE; // START_MAC
                    else                                             nxt = ST_LOCAL; // START_LOCAL
                end
            end
            ST_ISSUE: begin
                if (cur_kind == K_CFG && cur_we) nxt = ST_IDLE;  // POST_DONE
                else                             nxt = ST_WAIT;  // AWAIT
            end
            ST_WAIT:  if (done) nxt = ST_IDLE;                   // CAPTURE
            ST_LOCAL: nxt = ST_IDLE;                             // LOCAL_DONE
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        issue  = (state == ST_ISSUE);
        busy   = (state != ST_IDLE);
        finish = (state == ST_ISSUE && cur_kind == K_CFG && cur_we)
              || (state == ST_WAIT && done)
              || (state == ST_LOCAL);
    end

endmodule

// File: rtl/regbus_mac_bridge.sv
module regbus_mac_bridge
    import mac_bridge_pkg::*;
#(
    parameter int NUM_INST = 2,
    parameter int DATA_W   = 32,
    parameter int HADDR_W  = 10,
    parameter int CODE_W   = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_we,
    input  logic [1:0]                       bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    output logic [DATA_W-1:0]                bus_rdata,
    output logic [NUM_INST-1:0][HADDR_W-1:0] host_addr,
    output logic [NUM_INST-1:0][DATA_W-1:0]  host_wrdata,
    output logic [NUM_INST-1:0][1:0]         host_opcode,
    output logic [NUM_INST-1:0]              host_mgmt_sel,
    output logic [NUM_INST-1:0]              host_req,
    input  logic [NUM_INST-1:0][DATA_W-1:0]  host_rddata,
    input  logic [NUM_INST-1:0]              host_done
);

    localparam int SEL_W = (NUM_INST > 1) ? $clog2(NUM_INST) : 1;

    // Bus-side registers
    logic [DATA_W-1:0]  data_hi, data_lo;
    logic [CODE_W-1:0]  cur_code;
    logic               cur_we;
    logic [SEL_W-1:0]   cur_sel;
    kind_t              cur_kind;
    logic [HADDR_W-1:0] cur_haddr;
    logic [1:0]         cur_lidx;
    logic [NUM_INST-1:0] rdy;
    logic               err;

    // Bridge-local words
    logic [DATA_W-1:0]  int_stat, int_en, mgmt_wd;

    // Decode of an incoming control word
    logic [CODE_W-1:0]  new_code;
    logic               new_we;
    logic [SEL_W-1:0]   new_sel;
    kind_t              new_kind;
    logic [HADDR_W-1:0] new_haddr;
    logic [1:0]         new_lidx;

    bstate_t            state;
    logic               issue, busy, finish;
    logic               ctrl_wr, start;
    logic               done_sel;
    logic [DATA_W-1:0]  rd_result, local_word;
    logic               is_mgmt;
    logic [1:0]         acc_op;
    logic [DATA_W-1:0]  acc_wdata;

    assign new_code = bus_wdata[F_CODE_LSB +: CODE_W];
    assign new_we   = bus_wdata[F_WE_BIT];
    assign new_sel  = bus_wdata[F_SEL_LSB +: SEL_W];
    assign ctrl_wr  = bus_we && (bus_addr == RA_CTRL);
    assign start    = ctrl_wr && !busy;
    assign done_sel = host_done[cur_sel];

    mb_code_map #(.CODE_W(CODE_W), .HADDR_W(HADDR_W)) u_map (
        .code  (new_code),
        .kind  (new_kind),
        .haddr (new_haddr),
        .lidx  (new_lidx)
    );

    mb_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_kind (new_kind),
        .cur_kind   (cur_kind),
        .cur_we     (cur_we),
        .done       (done_sel),
        .state      (state),
        .issue      (issue),
        .busy       (busy),
        .finish     (finish)
    );

    // Access latch and ready/error tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_code  <= '0;
            cur_we    <= 1'b0;
            cur_sel   <= '0;
            cur_kind  <= K_NONE;
            cur_haddr <= '0;
            cur_lidx  <= 2'd0;
            rdy       <= '1;
            err       <= 1'b0;
        end else begin
            if (start) begin
                cur_code      <= new_code;
                cur_we        <= new_we;
                cur_sel       <= new_sel;
                cur_kind      <= new_kind;
                cur_haddr     <= new_haddr;
                cur_lidx      <= new_lidx;
                rdy[new_sel]  <= 1'b0;
            end
            if (finish) rdy[cur_sel] <= 1'b1;
            if (ctrl_wr && busy)
                err <= 1'b1;
            else if (bus_we && bus_addr == RA_RDY && bus_wdata[F_ERR_BIT])
                err <= 1'b0;
        end
    end

    // Read result: MAC data when waiting, otherwise local word or zero
    always_comb begin
        unique case (cur_lidx)
            2'd0:    local_word = int_stat;
            2'd1:    local_word = int_en;
            2'd2:    local_word = mgmt_wd;
            default: local_word = '0;
        endcase
        if (state == ST_WAIT)         rd_result = host_rddata[cur_sel];
        else if (cur_kind == K_LOCAL) rd_result = local_word;
        else                          rd_result = '0;
    end

    // Data pair: bus writes, overridden by read completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_hi <= '0;
            data_lo <= '0;
        end else if (finish && !cur_we) begin
            data_hi <= '0;
            data_lo <= rd_result;
        end else if (bus_we) begin
            if (bus_addr == RA_DHI) data_hi <= bus_wdata;
            if (bus_addr == RA_DLO) data_lo <= bus_wdata;
        end
    end

    // Local words written from data low in the LOCAL state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_stat <= '0;
            int_en   <= '0;
            mgmt_wd  <= '0;
        end else if (state == ST_LOCAL && cur_we && cur_kind == K_LOCAL) begin
            unique case (cur_lidx)
                2'd0:    int_stat <= data_lo;
                2'd1:    int_en   <= data_lo;
                2'd2:    mgmt_wd  <= data_lo;
                default: ;
            endcase
        end
    end

    // Strobe contents during ISSUE
    assign is_mgmt   = (cur_kind == K_MGMT);
    assign acc_op    = cur_we ? OP_WR : OP_RD;
    assign acc_wdata = is_mgmt ? mgmt_wd : data_lo;

    mb_host_fanout #(
        .NUM_INST (NUM_INST),
        .DATA_W   (DATA_W),
        .HADDR_W  (HADDR_W),
        .SEL_W    (SEL_W)
    ) u_fan (
        .active        (issue),
        .sel           (cur_sel),
        .addr          (cur_haddr),
        .wdata         (acc_wdata),
        .opcode        (acc_op),
        .msel          (is_mgmt),
        .req           (is_mgmt),
        .host_addr     (host_addr),
        .host_wrdata   (host_wrdata),
        .host_opcode   (host_opcode),
        .host_mgmt_sel (host_mgmt_sel),
        .host_req      (host_req)
    );

    // Bus read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            RA_DHI: bus_rdata = data_hi;
            RA_DLO: bus_rdata = data_lo;
            RA_CTRL: begin
                bus_rdata[F_CODE_LSB +: CODE_W] = cur_code;
                bus_rdata[F_WE_BIT]             = cur_we;
                bus_rdata[F_SEL_LSB +: SEL_W]   = cur_sel;
            end
            RA_RDY: begin
                bus_rdata[NUM_INST-1:0] = rdy;
                bus_rdata[F_ERR_BIT]    = err;
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mb_bridge_chk.sv
module mb_bridge_chk
    import mac_bridge_pkg::*;
#(
    parameter int NUM_INST = 2,
    parameter int DATA_W   = 32,
    parameter int HADDR_W  = 10,
    parameter int SEL_W    = 1
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             bus_we,
    input logic [1:0]                       bus_addr,
    input logic                             err_clr,
    input logic [NUM_INST-1:0][HADDR_W-1:0] host_addr,
    input logic [NUM_INST-1:0][DATA_W-1:0]  host_wrdata,
    input logic [NUM_INST-1:0][1:0]         host_opcode,
    input logic [NUM_INST-1:0]              host_mgmt_sel,
    input logic [NUM_INST-1:0]              host_req,
    input logic                             busy,
    input logic [NUM_INST-1:0]              rdy,
    input logic                             err,
    input logic [SEL_W-1:0]                 cur_sel
);

    logic [NUM_INST-1:0] act;
    always_comb begin
        for (int i = 0; i < NUM_INST; i++) act[i] = (host_opcode[i] != OP_IDLE);
    end

    // R5: only one instance strobed at a time
    p_single_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act));

    // R5: no strobe unless an access is pending
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (act == '0));

    // R3: ready of the chosen instance drops after a starting control write
    p_ready_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == RA_CTRL && !busy) |=> !rdy[cur_sel]);

    // R11: control write during a pending access raises the error flag
    p_busy_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == RA_CTRL && busy) |=> err);

    // R11: error flag holds until cleared
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(bus_we && bus_addr == RA_RDY && err_clr)) |=> err);

    for (genvar i = 0; i < NUM_INST; i++) begin : g_chk
        // R5: strobe lasts one cycle
        p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
            act[i] |=> !act[i]);
        // R5: quiet instance has all-zero inputs
        p_zero_when_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !act[i] |-> (host_addr[i] == '0 && host_wrdata[i] == '0
                         && !host_mgmt_sel[i] && !host_req[i]));
        // R7: configuration write completes one cycle after its strobe
        p_cfg_write_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (host_opcode[i] == OP_WR && !host_mgmt_sel[i]) |=> rdy[i]);
    end

endmodule

bind regbus_mac_bridge mb_bridge_chk #(
    .NUM_INST (NUM_INST),
    .DATA_W   (DATA_W),
    .HADDR_W  (HADDR_W),
    .SEL_W    (SEL_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .err_clr       (bus_wdata[8]),
    .host_addr     (host_addr),
    .host_wrdata   (host_wrdata),
    .host_opcode   (host_opcode),
    .host_mgmt_sel (host_mgmt_sel),
    .host_req      (host_req),
    .busy          (busy),
    .rdy           (rdy),
    .err           (err),
    .cur_sel       (cur_sel)
);

// File: tb/regbus_mac_bridge_tb_top.sv
`timescale 1ns/1ps
module regbus_mac_bridge_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [1:0]        bus_addr = 2'd0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [1:0][9:0]   host_addr;
    logic [1:0][31:0]  host_wrdata;
    logic [1:0][1:0]   host_opcode;
    logic [1:0]        host_mgmt_sel;
    logic [1:0]        host_req;
    logic [1:0][31:0]  host_rddata = '0;
    logic [1:0]        host_done = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct packed {
        logic [1:0]  inst;
        logic [9:0]  addr;
        logic [1:0]  op;
        logic [31:0] wd;
        logic        msel;
        logic        req;
    } xact_t;

    xact_t exp_q[$];

    always #2.5 clk = ~clk;

    regbus_mac_bridge dut_i (
        .clk (clk), .rst_n (rst_n),
        .bus_we (bus_we), .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .host_addr (host_addr), .host_wrdata (host_wrdata), .host_opcode (host_opcode),
        .host_mgmt_sel (host_mgmt_sel), .host_req (host_req),
        .host_rddata (host_rddata), .host_done (host_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input int sel, input bit we, input int code);
        return (32'(sel) << 16) | (32'(we) << 8) | 32'(code);
    endfunction

    function automatic logic [9:0] exp_addr(input int c);
        case (c)
            0: return 10'h200;  1: return 10'h240;  2: return 10'h280;  3: return 10'h2C0;
            4: return 10'h300;  5: return 10'h320;  6: return 10'h340;  7: return 10'h380;
            8: return 10'h384;  9: return 10'h388; 10: return 10'h38C; 11: return 10'h390;
            15: return 10'h3B4;
            default: return 10'h000;
        endcase
    endfunction

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic expect_x(input int inst, input int code, input bit we, input logic [31:0] wd);
        xact_t x;
        x.inst = 2'(inst); x.addr = exp_addr(code);
        x.op = we ? 2'b01 : 2'b10; x.wd = wd;
        x.msel = (code == 15); x.req = (code == 15);
        exp_q.push_back(x);
    endtask

    task automatic pulse_done(input int inst, input logic [31:0] rd);
        host_done[inst] = 1'b1; host_rddata[inst] = rd;
        @(negedge clk);
        host_done = '0; host_rddata = '0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int i = 0; i < 2; i++) begin
                if (host_opcode[i] != 2'b00) begin
                    xact_t a, e;
                    a.inst = 2'(i); a.addr = host_addr[i]; a.op = host_opcode[i];
                    a.wd = host_wrdata[i]; a.msel = host_mgmt_sel[i]; a.req = host_req[i];
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R5 unexpected strobe actual=%h expected=none", a);
                    end else begin
                        e = exp_q.pop_front();
                        if (a !== e) begin
                            errors++;
                            $display("FAIL R4 R5 R6 strobe actual=%h expected=%h", a, e);
                        end
                    end
                end else if (host_addr[i] != 0 || host_wrdata[i] != 0 || host_mgmt_sel[i] || host_req[i]) begin
                    checks++; errors++;
                    $display("FAIL R5 quiet instance %0d actual=%h expected=0", i, host_addr[i]);
                end
            end
        end
    end

    task automatic summary;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd3, r); check("R1 ready", r, 32'h3);
        bus_read(2'd1, r); check("R1 data lo", r, 32'h0);
        bus_read(2'd0, r); check("R1 data hi", r, 32'h0);
        bus_read(2'd2, r); check("R1 control", r, 32'h0);

        // R3 R6 R7 config write inst0, lowest bit only
        bus_write(2'd1, 32'h0000_0001);
        expect_x(0, 0, 1, 32'h0000_0001);
        bus_write(2'd2, mk_ctrl(0, 1, 0));
        bus_read(2'd3, r); check("R3 ready cleared", r, 32'h2);
        bus_read(2'd2, r); check("R2 control readback", r, mk_ctrl(0, 1, 0));
        @(negedge clk);
        bus_read(2'd3, r); check("R7 ready set", r, 32'h3);

        // R6 top bit, inst1
        bus_write(2'd1, 32'h8000_0000);
        expect_x(1, 11, 1, 32'h8000_0000);
        bus_write(2'd2, mk_ctrl(1, 1, 11));
        @(negedge clk);
        bus_read(2'd3, r); check("R7 ready inst1", r, 32'h3);

        // R4 every configuration code, alternating instances
        for (int c = 0; c < 12; c++) begin
            bus_write(2'd1, 32'hC0DE_0000 | 32'(c));
            expect_x(c % 2, c, 1, 32'hC0DE_0000 | 32'(c));
            bus_write(2'd2, mk_ctrl(c % 2, 1, c));
            @(negedge clk);
        end
        check("R4 all strobes seen", 32'(exp_q.size()), 32'd0);

        // R8 config read inst1 with done
        bus_write(2'd0, 32'h0000_1234);
        expect_x(1, 7, 0, 32'h8000_0000 | 32'(11));
        bus_write(2'd1, 32'h8000_000B);
        bus_write(2'd2, mk_ctrl(1, 0, 7));
        @(negedge clk);
        repeat (2) @(negedge clk);
        bus_read(2'd3, r); check("R8 ready held while waiting", r, 32'h1);
        pulse_done(1, 32'hDEAD_BEEF);
        bus_read(2'd3, r); check("R8 ready after done", r, 32'h3);
        bus_read(2'd1, r); check("R8 data lo captured", r, 32'hDEAD_BEEF);
        bus_read(2'd0, r); check("R8 data hi cleared", r, 32'h0);

        // R9 local write and read of interrupt enable (code 13)
        bus_write(2'd1, 32'h0000_0055);
        bus_write(2'd2, mk_ctrl(1, 1, 13));
        bus_read(2'd3, r); check("R9 local pending", r, 32'h1);
        @(negedge clk);
        bus_read(2'd3, r); check("R9 local done", r, 32'h3);
        bus_write(2'd1, 32'h0);
        bus_write(2'd0, 32'h0000_ABCD);
        bus_write(2'd2, mk_ctrl(1, 0, 13));
        @(negedge clk);
        bus_read(2'd1, r); check("R9 local read", r, 32'h55);
        bus_read(2'd0, r); check("R9 local hi zero", r, 32'h0);
        bus_write(2'd2, mk_ctrl(0, 0, 12));
        @(negedge clk);
        bus_read(2'd1, r); check("R1 R9 int status reset", r, 32'h0);

        // R6 R8 management control uses stored management word
        bus_write(2'd1, 32'h0000_1234);
        bus_write(2'd2, mk_ctrl(0, 1, 14));
        @(negedge clk);
        bus_write(2'd1, 32'hFFFF_0000);
        expect_x(0, 15, 1, 32'h0000_1234);
        bus_write(2'd2, mk_ctrl(0, 1, 15));
        repeat (3) @(negedge clk);
        bus_read(2'd3, r); check("R8 mgmt waits", r, 32'h2);
        pulse_done(0, 32'h0);
        bus_read(2'd3, r); check("R8 mgmt done", r, 32'h3);
        bus_read(2'd1, r); check("R8 mgmt write keeps data", r, 32'hFFFF_0000);

        // R11 control write while busy
        expect_x(0, 3, 0, 32'hFFFF_0000);
        bus_write(2'd2, mk_ctrl(0, 0, 3));
        @(negedge clk);
        bus_write(2'd2, mk_ctrl(1, 1, 5));
        bus_read(2'd2, r); check("R11 control unchanged", r, mk_ctrl(0, 0, 3));
        bus_read(2'd3, r); check("R11 error set", r, 32'h102);
        pulse_done(0, 32'h0BAD_F00D);
        bus_read(2'd1, r); check("R11 original read completes", r, 32'h0BAD_F00D);
        bus_read(2'd3, r); check("R11 error sticky", r, 32'h103);
        bus_write(2'd3, 32'h0000_0100);
        bus_read(2'd3, r); check("R11 error cleared", r, 32'h3);

        // R10 unmapped codes
        bus_write(2'd1, 32'h0000_0077);
        bus_write(2'd0, 32'h0000_0088);
        bus_write(2'd2, mk_ctrl(0, 0, 20));
        @(negedge clk);
        bus_read(2'd1, r); check("R10 unmapped read lo", r, 32'h0);
        bus_read(2'd0, r); check("R10 unmapped read hi", r, 32'h0);
        bus_read(2'd3, r); check("R10 unmapped ready", r, 32'h3);
        bus_write(2'd2, mk_ctrl(1, 1, 31));
        @(negedge clk);
        bus_read(2'd3, r); check("R10 unmapped write ready", r, 32'h3);

        repeat (3) @(negedge clk);
        check("R5 no missing strobes", 32'(exp_q.size()), 32'd0);
        summary();
    end

endmodule